// File: doc/BRIEF.md
# Delay/Divide Acquisition Strobe Synthesizer

This block chooses which input clock pulses become acquisition strobes for a qualified state-clock generator. All of its logic runs in one system clock domain. An input clock pulse arrives as a single-cycle enable, `pulse_en`. The block samples a synchronization reference, `esync`, and a hold input, `wait_in`, only on cycles where `pulse_en` is high.

The block has two active modes:
- **Delay mode.** An accepted sync pulse arms a one-shot. The one-shot fires a single strobe a programmed number of input pulses later.
- **Divide mode.** An accepted sync pulse sets the phase of a free-running divider. The divider then places a strobe on the last phase of every group of N input pulses, and needs no further sync.

`wait_in` stretches the count. Each pulse seen while it is high adds one pulse of delay, and no strobe is issued on that pulse. `wait_in` outranks a sync pulse on the same input pulse.

Mode and N are level inputs. The block captures them only when it accepts a sync pulse. The output `strobe_en` is combinational from the registered state and the current pulse. It drives the downstream clock qualifier in the same cycle as the pulse it selects.

Top module: `strobe_synth`

## Requirements
- R1: After reset the captured setting is delay with N=0, so `strobe_en` equals `pulse_en` regardless of the `mode_sel`/`n_sel` inputs.
- R2: `strobe_en` is never high in a cycle where `pulse_en` is low.
- R3: In the inactive settings (delay with N=0, divide with N=1), every input pulse is passed to `strobe_en`, and `esync` and `wait_in` have no effect on the output.
- R4: Delay mode with N in 1..4: an accepted sync pulse produces no strobe itself. It produces exactly one strobe, on the Nth later non-wait input pulse, and nothing more until the next sync.
- R5: Delay mode: an accepted sync pulse during a pending delay restarts the count from N, and the earlier pending strobe is dropped.
- R6: Divide mode with N in 2..4: the first strobe falls on the (N-1)th non-wait pulse after the last accepted sync pulse. Strobes then repeat every N non-wait pulses without further sync. A sync held over several pulses keeps re-anchoring the phase.
- R7: Divide mode: a later accepted sync pulse re-aligns the phase exactly as the first one did.
- R8: In an active setting, a pulse with `wait_in` high gives no strobe and does not advance the count. The next strobe therefore moves back by one pulse.
- R9: A pulse with both `esync` and `wait_in` high discards the sync: no restart, no realignment and no setting capture.
- R10: `mode_sel` (0 = delay, 1 = divide) and `n_sel` are captured only on an accepted sync pulse (`pulse_en`, `esync` high, `wait_in` low). That pulse itself is still governed by the setting captured before it.
- R11: An out-of-range `n_sel` is clamped: delay N above 4 acts as 4, divide N above 4 acts as 4, and divide N=0 acts as 1 (inactive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_en | input | 1 | One-cycle marker of an input clock pulse |
| esync | input | 1 | Synchronization reference, sampled on pulses |
| wait_in | input | 1 | Hold input, sampled on pulses |
| mode_sel | input | 1 | 0 = delay mode, 1 = divide mode (captured at sync) |
| n_sel | input | 3 | Delay count or divide ratio (captured at sync) |
| strobe_en | output | 1 | Acquisition strobe enable for the current pulse |

## Verification
The assertions check several rules on every cycle:
- a strobe only ever appears together with a pulse;
- the inactive settings pass pulses straight through;
- a wait pulse blocks the strobe and freezes both counters;
- an accepted sync pulse in an active setting is silent;
- the captured setting moves only on an accepted sync;
- both counters stay in range, and a delay strobe retires its pending delay.

Only the directed scenarios can show where strobes actually fall:
- the exact pulse index of the delay strobe and of the divide phase;
- the restart and realignment positions;
- that a discarded sync leaves the later strobe pattern unchanged;
- that clamped N values give the expected spacing.

// File: rtl/strobe_synth_pkg.sv
package strobe_synth_pkg;

    localparam int SYN_NW = 3;

    typedef enum logic {
        SYN_DELAY  = 1'b0,
        SYN_DIVIDE = 1'b1
    } syn_mode_e;

    typedef struct packed {
        syn_mode_e         mode;
        logic [SYN_NW-1:0] n;
    } syn_cfg_t;

    localparam syn_cfg_t SYN_CFG_RESET = '{mode: SYN_DELAY, n: '0};

    // Clamp a requested setting into the legal range of its mode.
    function automatic syn_cfg_t syn_normalize(
        input syn_mode_e         m,
        input logic [SYN_NW-1:0] n,
        input int unsigned       dly_max,
        input int unsigned       div_max
    );
        syn_cfg_t r;
        r.mode = m;
        r.n    = n;
        if (m == SYN_DELAY) begin
            if (32'(n) > dly_max) r.n = SYN_NW'(dly_max);
        end else begin
            if (32'(n) > div_max) r.n = SYN_NW'(div_max);
            if (n == '0)          r.n = SYN_NW'(1);
        end
        return r;
    endfunction

    // Delay 0 and divide 1 are pass-through settings.
    function automatic logic syn_is_active(input syn_cfg_t c);
        if (c.mode == SYN_DELAY) return (c.n != '0);
        return (c.n > SYN_NW'(1));
    endfunction

endpackage

// File: rtl/ss_cfg_reg.sv
module ss_cfg_reg
    import strobe_synth_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  syn_cfg_t cfg_in,
    output syn_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= SYN_CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/ss_delay_eng.sv
module ss_delay_eng
    import strobe_synth_pkg::*;
#(
    parameter int CNT_W = SYN_NW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             hold,
    input  logic             sync_ok,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_n,
    input  logic             run,
    output logic             strobe,
    output logic [CNT_W-1:0] cnt,
    output logic             pending
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic advance;

    // Count only ordinary pulses: not a wait pulse and not a sync pulse.
    assign advance = run && pulse && !hold && !sync_ok && pending;
    assign strobe  = advance && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (sync_ok) begin
            if (load_en) begin
                cnt     <= load_n;
                pending <= 1'b1;
            end else begin
                cnt     <= '0;
                pending <= 1'b0;
            end
        end else if (advance) begin
            if (cnt == ONE) begin
                cnt     <= '0;
                pending <= 1'b0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/ss_divide_eng.sv
module ss_divide_eng
    import strobe_synth_pkg::*;
#(
    parameter int CNT_W = SYN_NW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse,
    input  logic             hold,
    input  logic             sync_ok,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cur_n,
    output logic             strobe,
    output logic [CNT_W-1:0] cnt,
    output logic             armed
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic advance;

    assign advance = run && pulse && !hold && !sync_ok && armed;
    assign strobe  = advance && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (sync_ok) begin
            if (load_en) begin
                // The sync pulse is phase one; the strobe lands on phase N.
                cnt   <= load_n - ONE;
                armed <= 1'b1;
            end else begin
                cnt   <= '0;
                armed <= 1'b0;
            end
        end else if (advance) begin
            if (cnt == ONE) begin
                cnt <= cur_n;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/strobe_synth.sv
module strobe_synth
    import strobe_synth_pkg::*;
#(
    parameter int DLY_MAX = 4,
    parameter int DIV_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_en,
    input  logic              esync,
    input  logic              wait_in,
    input  logic              mode_sel,
    input  logic [SYN_NW-1:0] n_sel,
    output logic              strobe_en
);

    localparam int CNT_W = SYN_NW;

    syn_cfg_t         cfg_next;
    syn_cfg_t         cfg_q;
    logic             cfg_active;
    logic             next_active;
    logic             sync_ok;
    logic             dly_strobe;
    logic             div_strobe;
    logic [CNT_W-1:0] dly_cnt;
    logic [CNT_W-1:0] div_cnt;
    logic             dly_pending;
    logic             div_armed;
    logic             dly_load;
    logic             div_load;
    logic             dly_run;
    logic             div_run;

    // A sync counts only on a pulse and only when no wait is present.
    assign sync_ok     = pulse_en && esync && !wait_in;
    assign cfg_next    = syn_normalize(syn_mode_e'(mode_sel), n_sel,
                                       DLY_MAX, DIV_MAX);
    assign next_active = syn_is_active(cfg_next);
    assign cfg_active  = syn_is_active(cfg_q);

    assign dly_load = next_active && (cfg_next.mode == SYN_DELAY);
    assign div_load = next_active && (cfg_next.mode == SYN_DIVIDE);
    assign dly_run  = cfg_active  && (cfg_q.mode == SYN_DELAY);
    assign div_run  = cfg_active  && (cfg_q.mode == SYN_DIVIDE);

    ss_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (sync_ok),
        .cfg_in (cfg_next),
        .cfg_q  (cfg_q)
    );

    ss_delay_eng #(.CNT_W(CNT_W)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .pulse   (pulse_en),
        .hold    (wait_in),
        .sync_ok (sync_ok),
        .load_en (dly_load),
        .load_n  (cfg_next.n),
        .run     (dly_run),
        .strobe  (dly_strobe),
        .cnt     (dly_cnt),
        .pending (dly_pending)
    );

    ss_divide_eng #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .pulse   (pulse_en),
        .hold    (wait_in),
        .sync_ok (sync_ok),
        .load_en (div_load),
        .load_n  (cfg_next.n),
        .run     (div_run),
        .cur_n   (cfg_q.n),
        .strobe  (div_strobe),
        .cnt     (div_cnt),
        .armed   (div_armed)
    );

    always_comb begin
        if (cfg_active) begin
            strobe_en = dly_strobe || div_strobe;
        end else begin
            strobe_en = pulse_en;
        end
    end

endmodule

// File: rtl/strobe_synth_chk.sv
module strobe_synth_chk
    import strobe_synth_pkg::*;
#(
    parameter int DLY_MAX = 4,
    parameter int DIV_MAX = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              pulse_en,
    input logic              esync,
    input logic              wait_in,
    input logic              strobe_en,
    input logic              cfg_active,
    input syn_cfg_t          cfg_q,
    input logic [SYN_NW-1:0] dly_cnt,
    input logic [SYN_NW-1:0] div_cnt,
    input logic              dly_pending,
    input logic              div_armed
);

    assert_strobe_needs_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_en |-> pulse_en);

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_active |-> (strobe_en == pulse_en));

    assert_wait_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_active && wait_in) |-> !strobe_en);

    assert_wait_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse_en && wait_in) |=> ($stable(dly_cnt) && $stable(div_cnt)
                                    && $stable(dly_pending) && $stable(div_armed)));

    assert_sync_pulse_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_active && pulse_en && esync && !wait_in) |-> !strobe_en);

    assert_cfg_only_at_sync_R10: assert property (@(posedge clk) disable iff (rst)
        !(pulse_en && esync && !wait_in) |=> $stable(cfg_q));

    assert_delay_one_shot_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe_en && cfg_active && cfg_q.mode == SYN_DELAY) |=> !dly_pending);

    assert_divide_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_active && cfg_q.mode == SYN_DIVIDE && !div_armed) |-> !strobe_en);

    assert_count_range_R11: assert property (@(posedge clk) disable iff (rst)
        (32'(dly_cnt) <= DLY_MAX) && (32'(div_cnt) <= DIV_MAX));

endmodule

bind strobe_synth strobe_synth_chk #(.DLY_MAX(DLY_MAX), .DIV_MAX(DIV_MAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pulse_en    (pulse_en),
    .esync       (esync),
    .wait_in     (wait_in),
    .strobe_en   (strobe_en),
    .cfg_active  (cfg_active),
    .cfg_q       (cfg_q),
    .dly_cnt     (dly_cnt),
    .div_cnt     (div_cnt),
    .dly_pending (dly_pending),
    .div_armed   (div_armed)
);

// File: tb/tb_strobe_synth.sv
module tb_strobe_synth;

    logic       clk = 1'b0;
    logic       rst;
    logic       pulse_en;
    logic       esync;
    logic       wait_in;
    logic       mode_sel;
    logic [2:0] n_sel;
    logic       strobe_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    strobe_synth dut (
        .clk       (clk),
        .rst       (rst),
        .pulse_en  (pulse_en),
        .esync     (esync),
        .wait_in   (wait_in),
        .mode_sel  (mode_sel),
        .n_sel     (n_sel),
        .strobe_en (strobe_en)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: strobe_en=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // One input pulse with the given sync/wait levels, then one idle cycle.
    task automatic pulse(input logic e, input logic w, input logic exp, input string req);
        @(negedge clk);
        pulse_en = 1'b1; esync = e; wait_in = w;
        #1 check(req, strobe_en, exp);
        @(negedge clk);
        pulse_en = 1'b0; esync = 1'b0; wait_in = 1'b0;
        #1 check("R2 idle cycle", strobe_en, 1'b0);
    endtask

    task automatic set_cfg(input logic m, input logic [2:0] n);
        @(negedge clk);
        mode_sel = m; n_sel = n;
    endtask

    task automatic t_reset_R1;
        set_cfg(1'b1, 3'd3);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        pulse(0, 0, 1, "R1 pass after reset");
        pulse(0, 0, 1, "R1 pass after reset");
        pulse(0, 0, 1, "R10 inputs not captured");
    endtask

    task automatic t_delay_R4;
        set_cfg(1'b0, 3'd3);
        pulse(1, 0, 1, "R10 sync pulse uses old setting");
        pulse(0, 0, 0, "R4 pulse 1");
        pulse(0, 0, 0, "R4 pulse 2");
        pulse(0, 0, 1, "R4 strobe on pulse 3");
        pulse(0, 0, 0, "R4 one shot only");
        pulse(0, 0, 0, "R4 one shot only");
    endtask

    task automatic t_restart_R5;
        pulse(1, 0, 0, "R5 sync silent");
        pulse(0, 0, 0, "R5 pulse 1");
        pulse(1, 0, 0, "R5 restart");
        pulse(0, 0, 0, "R5 pulse 1 after restart");
        pulse(0, 0, 0, "R5 pulse 2 after restart");
        pulse(0, 0, 1, "R5 strobe after restart");
    endtask

    task automatic t_delay_wait_R8;
        pulse(1, 0, 0, "R8 sync");
        pulse(0, 0, 0, "R8 pulse 1");
        pulse(0, 1, 0, "R8 wait pulse");
        pulse(0, 0, 0, "R8 pulse 2");
        pulse(0, 0, 1, "R8 strobe pushed back");
        pulse(0, 0, 0, "R8 done");
    endtask

    task automatic t_wait_sync_R9;
        pulse(1, 0, 0, "R9 sync");
        pulse(0, 0, 0, "R9 pulse 1");
        pulse(1, 1, 0, "R9 sync with wait");
        pulse(0, 0, 0, "R9 pulse 2");
        pulse(0, 0, 1, "R9 sync was discarded");
        set_cfg(1'b1, 3'd2);
        pulse(1, 1, 0, "R9 capture discarded");
        pulse(0, 0, 0, "R9 still delay idle");
        pulse(0, 0, 0, "R9 still delay idle");
        pulse(0, 0, 0, "R9 still delay idle");
    endtask

    task automatic t_divide_R6;
        set_cfg(1'b1, 3'd3);
        pulse(1, 0, 0, "R6 sync silent");
        pulse(0, 0, 0, "R6 phase 2");
        pulse(0, 0, 1, "R6 first strobe");
        for (int k = 0; k < 2; k++) begin
            pulse(0, 0, 0, "R6 repeat");
            pulse(0, 0, 0, "R6 repeat");
            pulse(0, 0, 1, "R6 repeat strobe");
        end
        set_cfg(1'b1, 3'd2);
        pulse(0, 0, 0, "R10 ratio unchanged");
        pulse(0, 0, 0, "R10 ratio unchanged");
        pulse(0, 0, 1, "R10 ratio unchanged");
    endtask

    task automatic t_realign_R7;
        set_cfg(1'b1, 3'd3);
        pulse(1, 0, 0, "R7 sync");
        pulse(0, 0, 0, "R7 phase 2");
        pulse(1, 0, 0, "R7 resync");
        pulse(0, 0, 0, "R7 phase 2");
        pulse(0, 0, 1, "R7 realigned strobe");
        pulse(0, 0, 0, "R7 repeat");
        pulse(0, 0, 0, "R7 repeat");
        pulse(0, 0, 1, "R7 repeat strobe");
    endtask

    task automatic t_held_sync_R6;
        set_cfg(1'b1, 3'd2);
        pulse(1, 0, 0, "R6 held sync 1");
        pulse(1, 0, 0, "R6 held sync 2");
        pulse(0, 0, 1, "R6 after held sync");
        pulse(0, 0, 0, "R6 div2 gap");
        pulse(0, 0, 1, "R6 div2 strobe");
    endtask

    task automatic t_divide_wait_R8;
        set_cfg(1'b1, 3'd3);
        pulse(1, 0, 0, "R8 div sync");
        pulse(0, 0, 0, "R8 div phase 2");
        pulse(0, 1, 0, "R8 div wait");
        pulse(0, 0, 1, "R8 div strobe late");
        pulse(0, 0, 0, "R8 div repeat");
        pulse(0, 0, 0, "R8 div repeat");
        pulse(0, 0, 1, "R8 div repeat strobe");
    endtask

    task automatic t_inactive_R3;
        set_cfg(1'b1, 3'd1);
        pulse(1, 0, 0, "R3 sync under old divide");
        pulse(0, 1, 1, "R3 div1 wait ignored");
        pulse(0, 0, 1, "R3 div1 pass");
        pulse(1, 0, 1, "R3 div1 sync ignored");
        pulse(1, 1, 1, "R3 div1 both ignored");
        set_cfg(1'b0, 3'd0);
        pulse(1, 0, 1, "R3 dly0 sync");
        pulse(0, 1, 1, "R3 dly0 wait ignored");
        pulse(0, 0, 1, "R3 dly0 pass");
    endtask

    task automatic t_clamp_R11;
        set_cfg(1'b0, 3'd7);
        pulse(1, 0, 1, "R11 sync under old inactive");
        pulse(0, 0, 0, "R11 dly clamp 1");
        pulse(0, 0, 0, "R11 dly clamp 2");
        pulse(0, 0, 0, "R11 dly clamp 3");
        pulse(0, 0, 1, "R11 dly clamp strobe at 4");
        pulse(0, 0, 0, "R11 dly clamp done");
        set_cfg(1'b1, 3'd0);
        pulse(1, 0, 0, "R11 sync under delay");
        pulse(0, 0, 1, "R11 div0 acts as div1");
        pulse(0, 1, 1, "R11 div0 wait ignored");
        set_cfg(1'b1, 3'd6);
        pulse(1, 0, 1, "R11 sync under inactive");
        pulse(0, 0, 0, "R11 div clamp 2");
        pulse(0, 0, 0, "R11 div clamp 3");
        pulse(0, 0, 1, "R11 div clamp strobe at 4");
    endtask

    initial begin
        rst = 1'b1; pulse_en = 1'b0; esync = 1'b0; wait_in = 1'b0;
        mode_sel = 1'b0; n_sel = 3'd0;
        t_reset_R1();
        t_delay_R4();
        t_restart_R5();
        t_delay_wait_R8();
        t_wait_sync_R9();
        t_divide_R6();
        t_realign_R7();
        t_held_sync_R6();
        t_divide_wait_R8();
        t_inactive_R3();
        t_clamp_R11();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule